// File: doc/BRIEF.md
# Interval-Tracking Floppy Data Separator

This block recovers the bit stream from the flux-transition pulses of a floppy read channel. An oversampling clock runs at sixteen times the cell rate. A counter measures the number of clock cycles between successive transition pulses. Each interval is then matched against windows centred on whole multiples of an internally tracked cell period. The match yields the number of cells the interval spans. The block emits that many bits: zeros first, then a closing one, with one strobe per bit.

Spindle speed drifts slowly, so the expected period is not fixed. After every accepted interval, the block divides the timing error by the cell count and scales it by a programmable fraction in sixteenths. The result is added to the period, which gives a first-order tracking loop. Small gains suit clean media, and gains around one half to four fifths suit worn media. Intervals that fall outside the legal set are flagged and do not move the period. A long run of them restores the nominal period. A lock flag reports a sustained run of good intervals.

FM and MFM are supported by changing only the set of legal cell counts. The period is held in fixed point with FRAC fraction bits, so its unit is one clock divided by 2^FRAC.

Top module: `fdsep_top`

## Requirements
- R1: The interval is the number of clock cycles from one sampled pulse to the next. The first pulse after reset only starts the measurement and produces no bits and no error.
- R2: With mfm_sel=0 (FM), legal cell counts are 1 and 2. A count of k is chosen when the interval lies in [k*P - floor(P/2), k*P + ceil(P/2)) clocks, where P is the current period. At the nominal period of 16 clocks, intervals 8..23 give k=1 and 24..39 give k=2.
- R3: With mfm_sel=1 (MFM), legal cell counts are 2, 3 and 4, using the same windows. At the nominal period, intervals 24..71 are legal and everything else is out of range.
- R4: An out-of-range interval raises bad_interval for exactly one cycle, starting the cycle after the closing pulse. It emits no bits and leaves the period unchanged.
- R5: After an accepted interval of k cells, the period grows by gain/16 times (interval error / k), where gain is the 4-bit input. The period is clamped to 75%..125% of nominal. With gain=0 the period stays at nominal.
- R6: On the 32nd consecutive out-of-range interval the period reloads its nominal value. Fewer than 32 leave the tracked value in place.
- R7: locked rises once 16 consecutive intervals have been accepted. Any out-of-range interval clears it.
- R8: An accepted interval of k cells yields k strobes on consecutive cycles, beginning the cycle after the closing pulse. The bits are k-1 zeros followed by a one.
- R9: While and after reset, bit_valid, locked and bad_interval are low.
- R10: With a stream offset by up to ±3% in rate and ±1 clock of jitter, the recovered bits equal the transmitted ones for every gain tested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 16 per nominal cell |
| rst_n | input | 1 | Active-low synchronous reset |
| flux_pulse | input | 1 | One-cycle pulse per flux transition, synchronous to clk |
| mfm_sel | input | 1 | 0 selects FM cell set, 1 selects MFM cell set |
| gain | input | 4 | Loop gain in sixteenths |
| bit_data | output | 1 | Recovered bit, valid with bit_valid |
| bit_valid | output | 1 | One strobe per recovered bit |
| locked | output | 1 | Sustained run of accepted intervals |
| bad_interval | output | 1 | One-cycle flag for an out-of-range interval |

## Verification
The bench holds gain at zero and sweeps every interval length from 6 to 76 clocks in both encodings. A design with an off-by-one window edge, or with the wrong legal set for an encoding, would emit the wrong cell count or a missing or extra error exactly at 8, 24, 40 or 72 clocks. It then drives the block to a 12.5% slow rate and sends either 31 or 32 short error intervals, followed by one 25-clock interval. That interval decodes as one cell only while the tracked period survives, so a design that updates the period on errors, or reloads it one run too early or too late, emits the wrong bits. Random FM and MFM streams with rate offset and jitter check that the loop keeps every bit. The lock test checks the 15/16 boundary and that lock drops after one error.

// File: rtl/fdsep_pkg.sv
package fdsep_pkg;
    typedef enum logic {
        ENC_FM  = 1'b0,
        ENC_MFM = 1'b1
    } enc_e;

    localparam int MAX_CELLS = 4;

    typedef logic [2:0] ncell_t;
endpackage

// File: rtl/fdsep_interval.sv
module fdsep_interval #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    output logic [CNT_W-1:0] meas,
    output logic             armed
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pulse) begin
            st_d.cnt   = CNT_W'(1);
            st_d.armed = 1'b1;
        end else if (st_q.cnt != '1) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign meas  = st_q.cnt;
    assign armed = st_q.armed;
endmodule

// File: rtl/fdsep_quant.sv
module fdsep_quant
    import fdsep_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter int FRAC  = 4,
    parameter int PW    = 9,
    parameter int EW    = CNT_W + FRAC + 3
) (
    input  logic [CNT_W-1:0]     meas,
    input  logic [PW-1:0]        period,
    input  enc_e                 enc,
    output logic                 in_range,
    output ncell_t               ncell,
    output logic signed [EW-1:0] err_norm
);
    logic [EW-1:0]        ms;
    logic [EW-1:0]        half_lo;
    logic [EW-1:0]        half_hi;
    logic [EW-1:0]        kp [MAX_CELLS];
    logic [MAX_CELLS-1:0] hit;
    logic [MAX_CELLS-1:0] allow;
    logic [EW-1:0]        kp_sel;
    logic signed [EW-1:0] diff;
    logic signed [31:0]   dw;

    assign ms      = EW'(meas) << FRAC;
    assign half_lo = EW'(period >> 1);
    assign half_hi = EW'(period) - half_lo;

    for (genvar i = 0; i < MAX_CELLS; i++) begin : g_win
        assign kp[i]  = EW'(period) * EW'(i + 1);
        assign hit[i] = (ms >= kp[i] - half_lo) && (ms < kp[i] + half_hi);
    end

    assign allow = (enc == ENC_MFM) ? 4'b1110 : 4'b0011;

    always_comb begin
        in_range = 1'b0;
        ncell    = '0;
        kp_sel   = '0;
        for (int i = 0; i < MAX_CELLS; i++) begin
            if (hit[i] && allow[i] && !in_range) begin
                in_range = 1'b1;
                ncell    = ncell_t'(i + 1);
                kp_sel   = kp[i];
            end
        end
        diff = signed'(ms) - signed'(kp_sel);
        dw   = 32'(diff);
        case (ncell)
            3'd2:    err_norm = diff >>> 1;
            3'd3:    err_norm = EW'((dw * 32'sd21) >>> 6);
            3'd4:    err_norm = diff >>> 2;
            default: err_norm = diff;
        endcase
    end
endmodule

// File: rtl/fdsep_loop.sv
module fdsep_loop #(
    parameter int NOM_CLKS   = 16,
    parameter int FRAC       = 4,
    parameter int PW         = 9,
    parameter int EW         = 14,
    parameter int GAIN_W     = 4,
    parameter int LOCK_RUN   = 16,
    parameter int RELOAD_RUN = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample,
    input  logic                 in_range,
    input  logic signed [EW-1:0] err_norm,
    input  logic [GAIN_W-1:0]    gain,
    output logic [PW-1:0]        period,
    output logic                 locked,
    output logic                 bad
);
    localparam int LW = $clog2(LOCK_RUN + 1);
    localparam int BW = $clog2(RELOAD_RUN);
    localparam int AW = EW + GAIN_W;
    localparam logic [PW-1:0] NOM_P = PW'(NOM_CLKS << FRAC);
    localparam logic signed [AW-1:0] PMIN_S = AW'((NOM_CLKS - NOM_CLKS / 4) << FRAC);
    localparam logic signed [AW-1:0] PMAX_S = AW'((NOM_CLKS + NOM_CLKS / 4) << FRAC);

    typedef struct packed {
        logic [PW-1:0] period;
        logic [LW-1:0] lock_cnt;
        logic [BW-1:0] bad_cnt;
        logic          bad;
    } st_t;

    st_t st_d, st_q;
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] pn;

    always_comb begin
        acc = '0;
        for (int i = 0; i < GAIN_W; i++) begin
            if (gain[i]) acc = acc + (AW'(err_norm) <<< i);
        end
        pn = AW'(signed'({1'b0, st_q.period})) + (acc >>> GAIN_W);

        st_d     = st_q;
        st_d.bad = 1'b0;
        if (sample) begin
            if (in_range) begin
                if (pn < PMIN_S)      st_d.period = PW'(PMIN_S);
                else if (pn > PMAX_S) st_d.period = PW'(PMAX_S);
                else                  st_d.period = PW'(pn);
                if (st_q.lock_cnt != LW'(LOCK_RUN)) st_d.lock_cnt = st_q.lock_cnt + LW'(1);
                st_d.bad_cnt = '0;
            end else begin
                st_d.bad      = 1'b1;
                st_d.lock_cnt = '0;
                if (st_q.bad_cnt == BW'(RELOAD_RUN - 1)) begin
                    st_d.period  = NOM_P;
                    st_d.bad_cnt = '0;
                end else begin
                    st_d.bad_cnt = st_q.bad_cnt + BW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.period <= NOM_P;
        end else begin
            st_q <= st_d;
        end
    end

    assign period = st_q.period;
    assign locked = (st_q.lock_cnt == LW'(LOCK_RUN));
    assign bad    = st_q.bad;

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample |=> $stable(st_q.period));
    // R4
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !in_range && st_q.bad_cnt != BW'(RELOAD_RUN - 1)) |=> $stable(st_q.period));
    // R6
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !in_range && st_q.bad_cnt == BW'(RELOAD_RUN - 1)) |=> (st_q.period == NOM_P));
    // R7
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(sample && in_range));
endmodule

// File: rtl/fdsep_serial.sv
module fdsep_serial
    import fdsep_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load,
    input  ncell_t ncell,
    output logic   bit_valid,
    output logic   bit_data
);
    typedef struct packed {
        ncell_t pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load)                st_d.pend = ncell;
        else if (st_q.pend != 0) st_d.pend = st_q.pend - ncell_t'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_valid = (st_q.pend != 0);
    assign bit_data  = (st_q.pend == ncell_t'(1));

    // R8
    zero_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !bit_data) |=> bit_valid);
endmodule

// File: rtl/fdsep_top.sv
module fdsep_top
    import fdsep_pkg::*;
#(
    parameter int NOM_CLKS   = 16,
    parameter int FRAC       = 4,
    parameter int CNT_W      = 7,
    parameter int GAIN_W     = 4,
    parameter int LOCK_RUN   = 16,
    parameter int RELOAD_RUN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flux_pulse,
    input  logic              mfm_sel,
    input  logic [GAIN_W-1:0] gain,
    output logic              bit_data,
    output logic              bit_valid,
    output logic              locked,
    output logic              bad_interval
);
    localparam int PW = $clog2(NOM_CLKS * 2) + FRAC;
    localparam int EW = CNT_W + FRAC + 3;

    logic [CNT_W-1:0]     meas;
    logic                 armed;
    logic [PW-1:0]        period;
    logic                 in_range;
    ncell_t               ncell;
    logic signed [EW-1:0] err_norm;
    logic                 sample;

    assign sample = flux_pulse && armed;

    fdsep_interval #(.CNT_W(CNT_W)) u_int (
        .clk(clk), .rst_n(rst_n), .pulse(flux_pulse), .meas(meas), .armed(armed)
    );

    fdsep_quant #(.CNT_W(CNT_W), .FRAC(FRAC), .PW(PW), .EW(EW)) u_quant (
        .meas(meas), .period(period), .enc(enc_e'(mfm_sel)),
        .in_range(in_range), .ncell(ncell), .err_norm(err_norm)
    );

    fdsep_loop #(
        .NOM_CLKS(NOM_CLKS), .FRAC(FRAC), .PW(PW), .EW(EW), .GAIN_W(GAIN_W),
        .LOCK_RUN(LOCK_RUN), .RELOAD_RUN(RELOAD_RUN)
    ) u_loop (
        .clk(clk), .rst_n(rst_n), .sample(sample), .in_range(in_range),
        .err_norm(err_norm), .gain(gain), .period(period), .locked(locked),
        .bad(bad_interval)
    );

    fdsep_serial u_ser (
        .clk(clk), .rst_n(rst_n), .load(sample && in_range), .ncell(ncell),
        .bit_valid(bit_valid), .bit_data(bit_data)
    );

    // R8
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && !$past(bit_valid)) |-> $past(flux_pulse));
    // R1
    first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flux_pulse && !armed) |=> !bad_interval);
endmodule

// File: tb/sim_fdsep_top.sv
module sim_fdsep_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flux_pulse = 1'b0;
    logic       mfm_sel = 1'b0;
    logic [3:0] gain = 4'd0;
    logic       bit_data, bit_valid, locked, bad_interval;

    int tests = 0;
    int fails = 0;
    int rx_n = 0;
    int exp_n = 0;
    int err_seen = 0;
    int pend_n = 0;
    bit rx_bits [0:4095];
    bit exp_bits [0:4095];

    always #(CLK_PERIOD / 2) clk = ~clk;

    fdsep_top u0 (
        .clk(clk), .rst_n(rst_n), .flux_pulse(flux_pulse), .mfm_sel(mfm_sel),
        .gain(gain), .bit_data(bit_data), .bit_valid(bit_valid),
        .locked(locked), .bad_interval(bad_interval)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid && rx_n < 4096) begin
                rx_bits[rx_n] = bit_data;
                rx_n++;
            end
            if (bad_interval) err_seen++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        flux_pulse = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rx_n = 0; exp_n = 0; err_seen = 0; pend_n = 0;
    endtask

    // pulse now, next pulse c cycles later
    task automatic send(input int c);
        @(negedge clk); flux_pulse = 1'b1;
        @(negedge clk); flux_pulse = 1'b0;
        repeat (c - 2) @(negedge clk);
    endtask

    task automatic tx(input int n, input int c);
        for (int b = 1; b <= pend_n; b++) begin
            exp_bits[exp_n] = (b == pend_n);
            exp_n++;
        end
        send(c);
        pend_n = n;
    endtask

    task automatic finish_stream();
        tx(0, 10);
        repeat (6) @(negedge clk);
    endtask

    task automatic cmp_bits(input string req);
        int bad_at;
        bad_at = -1;
        for (int i = 0; i < exp_n && i < rx_n; i++)
            if (bad_at < 0 && rx_bits[i] != exp_bits[i]) bad_at = i;
        if (rx_n != exp_n) chk(1'b0, {req, " bit count"}, rx_n, exp_n);
        else if (bad_at >= 0) chk(1'b0, {req, " bit value"}, int'(rx_bits[bad_at]), int'(exp_bits[bad_at]));
        else chk(1'b1, req, 0, 0);
    endtask

    function automatic int cells_at_nominal(input bit mfm, input int c);
        int k;
        k = (c + 8) / 16;
        if (mfm) return (k >= 2 && k <= 4) ? k : 0;
        return (k >= 1 && k <= 2) ? k : 0;
    endfunction

    task automatic sweep(input bit mfm, input string req);
        int n_err;
        do_reset();
        mfm_sel = mfm; gain = 4'd0; n_err = 0;
        for (int c = 6; c <= 76; c++) begin
            int n;
            n = cells_at_nominal(mfm, c);
            if (n == 0) n_err++;
            tx(n, c);
        end
        finish_stream();
        cmp_bits(req);
        chk(err_seen == n_err, {req, " R4 error count"}, err_seen, n_err);
    endtask

    task automatic run_random(input bit mfm, input int tq, input int g, input string req);
        do_reset();
        mfm_sel = mfm; gain = 4'(g);
        for (int i = 0; i < 150; i++) begin
            int n, c;
            n = mfm ? int'($urandom_range(2, 4)) : int'($urandom_range(1, 2));
            c = (n * tq + 8) / 16 + int'($urandom_range(0, 2)) - 1;
            tx(n, c);
        end
        finish_stream();
        cmp_bits({req, " R10"});
        chk(locked == 1'b1, {req, " R7 locked"}, int'(locked), 1);
        chk(err_seen == 0, {req, " R4 no errors"}, err_seen, 0);
    endtask

    task automatic drift(input int nerr, input int exp_cells, input string req);
        do_reset();
        mfm_sel = 1'b0; gain = 4'd12;
        for (int i = 0; i < 100; i++) begin
            int n;
            n = int'($urandom_range(1, 2));
            tx(n, 18 * n);
        end
        for (int i = 0; i < nerr; i++) tx(0, 4);
        tx(exp_cells, 25);
        finish_stream();
        cmp_bits(req);
        chk(err_seen == nerr, {req, " R4 error count"}, err_seen, nerr);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R9
        chk(bit_valid == 1'b0, "R9 bit_valid after reset", int'(bit_valid), 0);
        chk(locked == 1'b0, "R9 locked after reset", int'(locked), 0);
        chk(bad_interval == 1'b0, "R9 bad_interval after reset", int'(bad_interval), 0);

        // R1: a lone first pulse emits nothing
        mfm_sel = 1'b0; gain = 4'd8;
        send(20);
        chk(rx_n == 0 && err_seen == 0, "R1 first pulse silent", rx_n + err_seen, 0);

        // R2, R3: exhaustive interval sweep at nominal period
        sweep(1'b0, "R2 FM sweep");
        sweep(1'b1, "R3 MFM sweep");

        // R7: lock boundary and drop
        do_reset();
        mfm_sel = 1'b0; gain = 4'd8;
        for (int i = 0; i < 16; i++) tx(2, 32);
        chk(locked == 1'b0, "R7 not locked after 15", int'(locked), 0);
        tx(2, 32);
        chk(locked == 1'b1, "R7 locked after 16", int'(locked), 1);
        tx(0, 4);
        tx(0, 32);
        chk(locked == 1'b0, "R7 lock cleared by error", int'(locked), 0);

        // R5: gain zero keeps nominal period
        do_reset();
        mfm_sel = 1'b0; gain = 4'd0;
        for (int i = 0; i < 20; i++) begin
            int n;
            n = int'($urandom_range(1, 2));
            tx(n, 18 * n);
        end
        tx(2, 25);
        finish_stream();
        cmp_bits("R5 gain zero holds period");

        // R5, R4: 31 errors keep tracked period; R6: 32 reload nominal
        drift(31, 1, "R5 R4 tracked period kept");
        drift(32, 2, "R6 period reloaded");

        // R10 / R8: random streams with offset and jitter
        run_random(1'b1, 264, 8, "MFM +3% g8 R8");
        run_random(1'b1, 248, 12, "MFM -3% g12");
        run_random(1'b0, 264, 4, "FM +3% g4");
        run_random(1'b0, 248, 13, "FM -3% g13");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule